// File: doc/BRIEF.md
# Keyed Software Watchdog Timer

This block is a watchdog timer for a microcontroller-style subsystem. A timeout counter advances on ticks from an optional power-of-two prescaler. Software keeps the counter from expiring by writing a two-step key to a service register: first an arming value, then a firing value. Any number of other register writes may fall between the two steps. When the counter expires, the block raises either a one-cycle system reset request or a sticky interrupt request, as the configuration selects.

Software programs the block through a plain write strobe with a 2-bit address and an 8-bit data bus. Address 0 is the configuration register, address 1 is the service key register and address 2 is the interrupt vector register. Address 3 is ignored. While the interrupt acknowledge input is high, the block drives the stored vector onto its vector output. A freeze input, intended for debug halts, stops all counting and keeps the count.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, both request outputs and `ack_vec` are low. The configuration resets to enabled, reset mode, prescaler on and tap select 3, so the first reset pulse comes 2^(TAP_BASE+3*TAP_STEP)·2^PRE_BITS cycles after reset is released.
- R2: Writing 0x55 and then 0xAA to address 1 restarts the prescaler and the counter. Any writes in between, including other values written to address 1 and repeated 0x55 writes, do not break the sequence.
- R3: A write of 0xAA to address 1 with no pending 0x55 does not restart the count. A second 0xAA after a completed pair does not restart it either. Values other than 0x55 and 0xAA leave the pending state unchanged.
- R4: Configuration bits [1:0] select a timeout of 2^(TAP_BASE+TAP_STEP·sel) ticks. Bit 2 set makes one tick last 2^PRE_BITS clock cycles; bit 2 clear makes one tick last one cycle.
- R5: With configuration bit 3 clear (reset mode), `rst_req` goes high for exactly one cycle at expiry, and counting restarts from zero.
- R6: With configuration bit 3 set (interrupt mode), `irq_req` goes high at expiry and stays high until a cycle with `irq_ack` high. Counting restarts from zero.
- R7: While `irq_ack` is high, `ack_vec` equals the last value written to address 2. Otherwise `ack_vec` is zero.
- R8: With configuration bit 4 (enable) clear, counting stops and both request outputs are low. A pending interrupt is kept and reappears when the block is enabled again.
- R9: While `freeze` is high, the prescaler and the counter hold their values. Each frozen cycle delays expiry by exactly one cycle.
- R10: Any write to address 0 restarts the prescaler and the counter from zero.
- R11: An expiry cancels a pending 0x55, so a 0xAA that follows the expiry does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze | input | 1 | Holds prescaler and counter while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 config, 1 key, 2 vector |
| wr_data | input | 8 | Write data |
| irq_ack | input | 1 | Interrupt acknowledge; clears the interrupt request |
| rst_req | output | 1 | One-cycle system reset request |
| irq_req | output | 1 | Sticky interrupt request |
| ack_vec | output | 8 | Vector register value while `irq_ack` is high, else zero |

## Verification
The bench builds the block with PRE_BITS=2, CHAIN_BITS=6, TAP_BASE=3 and TAP_STEP=1. This gives timeouts of 8, 16, 32 and 64 ticks and a prescale factor of 4. Every tap and both prescaler settings can therefore expire within a few hundred cycles. Exact expiry cycles can be compared after service sequences, freezes, reconfiguration and disarming by expiry. The default widths give the same structure with longer chains, and the bench does not exercise them.

// File: rtl/wdsv_pkg.sv
`timescale 1ns/1ps
package wdsv_pkg;

    localparam logic [1:0] ADDR_CFG = 2'd0;
    localparam logic [1:0] ADDR_KEY = 2'd1;
    localparam logic [1:0] ADDR_VEC = 2'd2;

    localparam logic [7:0] KEY_ARM  = 8'h55;
    localparam logic [7:0] KEY_FIRE = 8'hAA;

    // config register layout: [4] enable, [3] irq mode, [2] prescale, [1:0] tap
    typedef struct packed {
        logic       enable;
        logic       irq_mode;
        logic       pre_en;
        logic [1:0] tap;
    } cfg_t;

    localparam cfg_t CFG_RST = '{enable: 1'b1, irq_mode: 1'b0, pre_en: 1'b1, tap: 2'd3};

endpackage

// File: rtl/wd_prescale.sv
`timescale 1ns/1ps
module wd_prescale #(
    parameter int PRE_BITS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic pre_en,
    input  logic clr,
    output logic tick
);
    typedef struct packed {
        logic [PRE_BITS-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (run) begin
            if (!pre_en) begin
                tick = 1'b1;
            end else begin
                tick     = (st_q.cnt == '1);
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wd_chain.sv
`timescale 1ns/1ps
module wd_chain #(
    parameter int CHAIN_BITS = 15,
    parameter int TAP_BASE   = 9,
    parameter int TAP_STEP   = 2,
    localparam int CW        = CHAIN_BITS + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clr,
    input  logic [1:0]    tap,
    output logic          expire,
    output logic [CW-1:0] count_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } chain_st_t;

    chain_st_t     st_d, st_q;
    logic [CW-1:0] lim [4];
    logic [CW-1:0] nxt;

    for (genvar g = 0; g < 4; g++) begin : g_tap
        assign lim[g] = CW'(1) << (TAP_BASE + TAP_STEP * g);
    end

    assign nxt = st_q.cnt + 1'b1;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (nxt == lim[tap]) begin
                expire   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
endmodule

// File: rtl/wd_key.sv
`timescale 1ns/1ps
module wd_key
    import wdsv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       flush,
    output logic       done,
    output logic       armed_o
);
    typedef struct packed {
        logic armed;
    } key_st_t;

    key_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = key_wr && (key_data == KEY_FIRE) && st_q.armed;
        if (flush) begin
            st_d.armed = 1'b0;
        end else if (key_wr) begin
            if (key_data == KEY_ARM)       st_d.armed = 1'b1;
            else if (key_data == KEY_FIRE) st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed_o = st_q.armed;
endmodule

// File: rtl/svc_watchdog.sv
`timescale 1ns/1ps
module svc_watchdog
    import wdsv_pkg::*;
#(
    parameter int PRE_BITS   = 9,
    parameter int CHAIN_BITS = 15,
    parameter int TAP_BASE   = 9,
    parameter int TAP_STEP   = 2,
    localparam int CNT_W     = CHAIN_BITS + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       freeze,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       irq_ack,
    output logic       rst_req,
    output logic       irq_req,
    output logic [7:0] ack_vec
);
    typedef struct packed {
        cfg_t       cfg;
        logic [7:0] vec;
        logic       rst;
        logic       irq;
    } top_st_t;

    top_st_t            st_d, st_q;
    logic               cfg_wr, key_wr, vec_wr;
    logic               run, restart, tick, expire, svc_done, armed;
    logic [CNT_W-1:0]   chain_cnt;

    assign cfg_wr  = wr_en && (wr_addr == ADDR_CFG);
    assign key_wr  = wr_en && (wr_addr == ADDR_KEY);
    assign vec_wr  = wr_en && (wr_addr == ADDR_VEC);
    assign run     = st_q.cfg.enable && !freeze;
    assign restart = cfg_wr || svc_done;

    wd_prescale #(.PRE_BITS(PRE_BITS)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .pre_en (st_q.cfg.pre_en),
        .clr    (restart),
        .tick   (tick)
    );

    wd_chain #(
        .CHAIN_BITS (CHAIN_BITS),
        .TAP_BASE   (TAP_BASE),
        .TAP_STEP   (TAP_STEP)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clr     (restart),
        .tap     (st_q.cfg.tap),
        .expire  (expire),
        .count_o (chain_cnt)
    );

    wd_key u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_data (wr_data),
        .flush    (expire),
        .done     (svc_done),
        .armed_o  (armed)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rst = 1'b0;
        if (cfg_wr)  st_d.cfg = cfg_t'(wr_data[4:0]);
        if (vec_wr)  st_d.vec = wr_data;
        if (irq_ack) st_d.irq = 1'b0;
        if (expire) begin
            if (st_q.cfg.irq_mode) st_d.irq = 1'b1;
            else                   st_d.rst = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cfg <= CFG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_req = st_q.rst && st_q.cfg.enable;
    assign irq_req = st_q.irq && st_q.cfg.enable;
    assign ack_vec = irq_ack ? st_q.vec : 8'h00;
endmodule

// File: rtl/wdsv_chk.sv
`timescale 1ns/1ps
module wdsv_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          freeze,
    input logic          restart,
    input logic          rst_req,
    input logic          irq_req,
    input logic          irq_ack,
    input logic          irq_q,
    input logic          done,
    input logic          armed,
    input logic [CW-1:0] chain_cnt
);
    // R8
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!rst_req && !irq_req));

    // R5
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R5
    rst_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (chain_cnt == '0));

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_ack) |=> irq_q);

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !restart) |=> $stable(chain_cnt));

    // R3
    key_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !armed);
endmodule

bind svc_watchdog wdsv_chk #(.CW(CNT_W)) i_wdsv_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (st_q.cfg.enable),
    .freeze    (freeze),
    .restart   (restart),
    .rst_req   (rst_req),
    .irq_req   (irq_req),
    .irq_ack   (irq_ack),
    .irq_q     (st_q.irq),
    .done      (svc_done),
    .armed     (armed),
    .chain_cnt (chain_cnt)
);

// File: tb/test_svc_watchdog.sv
`timescale 1ns/1ps
module test_svc_watchdog;
    localparam int PB  = 2;
    localparam int CB  = 6;
    localparam int TB0 = 3;
    localparam int TS  = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       freeze = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       irq_ack = 1'b0;
    logic       rst_req, irq_req;
    logic [7:0] ack_vec;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int mark = 0;
    bit finished = 0;

    svc_watchdog #(.PRE_BITS(PB), .CHAIN_BITS(CB), .TAP_BASE(TB0), .TAP_STEP(TS)) i_svc_watchdog (
        .clk(clk), .rst_n(rst_n), .freeze(freeze), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq_ack(irq_ack), .rst_req(rst_req), .irq_req(irq_req),
        .ack_vec(ack_vec)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int tlen(input int tap, input bit pre);
        return (1 << (TB0 + TS * tap)) * (pre ? (1 << PB) : 1);
    endfunction

    function automatic logic [7:0] cfgv(input bit en, input bit irqm, input bit pre, input int tap);
        return {3'b000, en, irqm, pre, 2'(tap)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        mark = cyc;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_event(input int lim, output int at, output logic g_rst, output logic g_irq);
        at = -1; g_rst = 1'b0; g_irq = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(posedge clk); #1;
            if (rst_req || irq_req) begin
                at = cyc; g_rst = rst_req; g_irq = irq_req;
                break;
            end
        end
    endtask

    task automatic count_high(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (rst_req || irq_req) hits++;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        finish_run();
    end

    initial begin
        int at, at2, base, hits, c;
        logic gr, gi;
        void'($urandom(32'd4711));

        // R1 reset state and default timeout
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        base = cyc;
        #1;
        check("R1 rst_req after reset", int'(rst_req), 0);
        check("R1 irq_req after reset", int'(irq_req), 0);
        check("R1 ack_vec after reset", int'(ack_vec), 0);
        wait_event(600, at, gr, gi);
        check("R1 default expiry cycle", at - base, tlen(3, 1));
        check("R5 default mode is reset", int'(gr), 1);
        idle(1);
        check("R5 rst pulse one cycle", int'(rst_req), 0);
        wait_event(600, at2, gr, gi);
        check("R5 restart after expiry", at2 - at, tlen(3, 1));

        // R4 / R10 tap sweep without prescaler
        for (int t = 0; t < 4; t++) begin
            wr(2'd0, cfgv(1, 0, 0, t));
            c = mark;
            wait_event(600, at, gr, gi);
            check("R4 tap length", at - c, tlen(t, 0));
        end
        wr(2'd0, cfgv(1, 0, 1, 1));
        c = mark;
        wait_event(600, at, gr, gi);
        check("R4 prescaled length", at - c, tlen(1, 1));

        // R10 rewrite of config mid-count restarts
        wr(2'd0, cfgv(1, 0, 0, 1));
        idle(9);
        wr(2'd0, cfgv(1, 0, 0, 1));
        c = mark;
        wait_event(600, at, gr, gi);
        check("R10 config write restarts", at - c, tlen(1, 0));

        // R2 service with interleaved accesses
        wr(2'd0, cfgv(1, 0, 0, 2));
        idle(10);
        wr(2'd1, 8'h55);
        wr(2'd2, 8'h3C);
        wr(2'd1, 8'h12);
        wr(2'd1, 8'h55);
        wr(2'd3, 8'hAA);
        wr(2'd1, 8'hAA);
        c = mark;
        wait_event(600, at, gr, gi);
        check("R2 service restarts count", at - c, tlen(2, 0));

        // R3 unarmed 0xAA and other values do not service
        wr(2'd0, cfgv(1, 0, 0, 2));
        c = mark;
        idle(4);
        wr(2'd1, 8'hAA);
        wr(2'd1, 8'h77);
        wait_event(600, at, gr, gi);
        check("R3 unarmed AA ignored", at - c, tlen(2, 0));
        wr(2'd0, cfgv(1, 0, 0, 2));
        wr(2'd1, 8'h55);
        wr(2'd1, 8'hAA);
        c = mark;
        idle(3);
        wr(2'd1, 8'hAA);
        wait_event(600, at, gr, gi);
        check("R3 second AA ignored", at - c, tlen(2, 0));

        // R11 expiry cancels pending arm
        wr(2'd0, cfgv(1, 0, 0, 0));
        c = mark;
        wr(2'd1, 8'h55);
        wait_event(600, at, gr, gi);
        check("R11 expiry cycle", at - c, tlen(0, 0));
        wr(2'd1, 8'hAA);
        wait_event(600, at2, gr, gi);
        check("R11 AA after expiry ignored", at2 - at, tlen(0, 0));

        // R6 / R7 interrupt mode, sticky request, vector on acknowledge
        wr(2'd0, cfgv(1, 1, 0, 3));
        c = mark;
        wait_event(600, at, gr, gi);
        check("R6 irq expiry cycle", at - c, tlen(3, 0));
        check("R6 irq raised", int'(gi), 1);
        check("R6 no rst in irq mode", int'(gr), 0);
        idle(20);
        check("R6 irq held", int'(irq_req), 1);
        check("R7 ack_vec zero without ack", int'(ack_vec), 0);
        @(negedge clk);
        irq_ack = 1'b1;
        #1;
        check("R7 ack_vec shows vector", int'(ack_vec), 8'h3C);
        @(posedge clk); #1;
        irq_ack = 1'b0;
        check("R6 irq cleared by ack", int'(irq_req), 0);

        // R8 disable suppresses and keeps pending interrupt
        wait_event(600, at2, gr, gi);
        check("R6 irq period", at2 - at, tlen(3, 0));
        wr(2'd0, cfgv(0, 1, 0, 3));
        check("R8 irq masked when disabled", int'(irq_req), 0);
        count_high(200, hits);
        check("R8 no output when disabled", hits, 0);
        wr(2'd0, cfgv(1, 1, 0, 3));
        check("R8 pending irq returns", int'(irq_req), 1);
        @(negedge clk); irq_ack = 1'b1;
        @(posedge clk); #1; irq_ack = 1'b0;
        check("R8 ack after re-enable", int'(irq_req), 0);
        wr(2'd0, cfgv(0, 0, 0, 0));
        count_high(200, hits);
        check("R8 reset mode disabled", hits, 0);

        // R9 freeze holds count
        wr(2'd0, cfgv(1, 0, 0, 1));
        c = mark;
        idle(3);
        @(negedge clk); freeze = 1'b1;
        repeat (7) @(posedge clk);
        @(negedge clk); freeze = 1'b0;
        wait_event(600, at, gr, gi);
        check("R9 freeze delays expiry", at - c, tlen(1, 0) + 7);
        wr(2'd0, cfgv(1, 0, 1, 0));
        c = mark;
        idle(5);
        @(negedge clk); freeze = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk); freeze = 1'b0;
        wait_event(600, at, gr, gi);
        check("R9 freeze with prescaler", at - c, tlen(0, 1) + 5);

        // R2 R3 R4 random mix
        for (int k = 0; k < 12; k++) begin
            int tap, nj;
            bit pre, svc;
            logic [7:0] v;
            tap = int'($urandom % 4);
            pre = 1'($urandom % 2);
            svc = 1'($urandom % 2);
            wr(2'd0, cfgv(1, 0, pre, tap));
            base = mark;
            for (int p = 0; p < (svc ? 2 : 1); p++) begin
                nj = int'($urandom % 3);
                for (int j = 0; j < nj; j++) begin
                    v = 8'($urandom);
                    if (v == 8'h55 || v == 8'hAA) v = 8'h11;
                    case ($urandom % 3)
                        0: wr(2'd1, v);
                        1: wr(2'd2, v);
                        default: wr(2'd3, 8'h55);
                    endcase
                end
                if (svc && p == 0) wr(2'd1, 8'h55);
            end
            if (svc) begin
                wr(2'd1, 8'hAA);
                base = mark;
            end
            wait_event(600, at, gr, gi);
            check("R2 R4 random expiry", at - base, tlen(tap, pre));
        end

        finish_run();
    end
endmodule